// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch-side control state for every hardware thread of a multithreaded front end. Each thread has its own state machine, its own sticky stall flags (one per downstream stage), its own fetch address and next address, and its own request tag counter. Each cycle, a fixed priority order decides what happens to each thread. A commit-side redirect comes first. A commit report that squashing is still under way comes next, then a decode-side redirect, then a stall, then recovery to running. Only after all of these are ruled out can the cache side move the thread.

The instruction cache is reached through one request port. A refused request is kept in a single retry slot shared by all threads. While that slot is occupied, no thread can start a new request. Cache responses carry a thread number and a tag. A response is only accepted by a thread that is waiting for exactly that tag, so answers to redirected or abandoned requests fall away. A stage-active output tells the surrounding pipeline whether any enabled thread can make progress.

Top module: `fetch_status_ctl`

## Requirements
- R1: After reset every thread is in state Running (status code 0), its address equals RESET_PC and its next address equals RESET_PC+INST_BYTES. No request is presented while no thread is selected. Status codes are: Running 0, Idle 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessDone 6, TrapWait 7, QuiesceWait 8.
- R2: Each thread has one stall flag per downstream stage, and bit t*NS+s of the set and clear inputs addresses stage s of thread t. A set pulse raises the flag and it stays raised until a clear pulse. The thread goes to Blocked in the cycle after a flag is set and stays there while any of its flags is raised. Set and clear of the same flag never arrive together.
- R3: While the context-switch input is high, every thread that is not in WaitResponse goes to Blocked.
- R4: A commit redirect for a thread takes precedence over every other event. It loads the address with the target, loads the next address with target+INST_BYTES and enters Squashing, one cycle later.
- R5: While commit reports that squashing is still under way for a thread, the thread stays in Squashing. A thread in Squashing or Blocked that sees no redirect and no stall returns to Running one cycle later.
- R6: A decode redirect loads the address with the target and the next address with target+INST_BYTES, and enters Squashing. It is ignored when the thread is already in Squashing or when commit still reports squashing.
- R7: Stall flags and context switch do not move a thread out of WaitResponse.
- R8: A Running thread that is selected while the retry slot is empty presents a request in the same cycle. The request carries the thread number, the address with its low log2(LINE_BYTES) bits cleared, and a tag one above that thread's previous tag (the first tag after reset is 1). If the cache accepts it in that cycle, the thread enters WaitResponse.
- R9: A refused request goes into the retry slot and its thread enters WaitRetry. The held request stays presented unchanged, and no other request can start. When the cache accepts the held request, the slot empties and its owner moves to WaitResponse.
- R10: A redirect of the thread that owns the retry slot empties the slot, and this reopens the cache to new requests.
- R11: A response is accepted only when its thread is in WaitResponse and its tag equals that thread's outstanding tag. An accepted response moves the thread to Blocked if a stall flag or context switch is raised, and to AccessDone otherwise. Any other response leaves all state unchanged.
- R12: A thread in AccessDone moves to Running in the cycle after it is next selected, and stays in AccessDone while other threads are selected.
- R13: The stage-active output is high exactly when some thread whose enable bit is set is in Running, Squashing or AccessDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_act_i | input | NT | Thread enable bits for the stage-active result |
| stall_set_i | input | NT*NS | Stall flag set pulses, bit t*NS+s |
| stall_clr_i | input | NT*NS | Stall flag clear pulses, bit t*NS+s |
| ctx_switch_i | input | 1 | Context switch in progress |
| cmt_sq_vld_i | input | 1 | Commit redirect valid |
| cmt_sq_tid_i | input | TID_W | Commit redirect thread |
| cmt_sq_pc_i | input | ADDR_W | Commit redirect target |
| cmt_still_sq_i | input | NT | Commit still squashing, per thread |
| dec_sq_vld_i | input | 1 | Decode redirect valid |
| dec_sq_tid_i | input | TID_W | Decode redirect thread |
| dec_sq_pc_i | input | ADDR_W | Decode redirect target |
| fetch_go_i | input | 1 | A thread is selected for fetch this cycle |
| fetch_tid_i | input | TID_W | Selected thread |
| req_vld_o | output | 1 | Cache request presented |
| req_tid_o | output | TID_W | Request thread |
| req_addr_o | output | ADDR_W | Line-aligned request address |
| req_tag_o | output | TAG_W | Request tag |
| req_rdy_i | input | 1 | Cache accepts the presented request |
| rsp_vld_i | input | 1 | Cache response valid |
| rsp_tid_i | input | TID_W | Response thread |
| rsp_tag_i | input | TAG_W | Response tag |
| status_o | output | NT*4 | Thread states, 4 bits per thread |
| pc_o | output | NT*ADDR_W | Fetch address per thread |
| npc_o | output | NT*ADDR_W | Next address per thread |
| stage_active_o | output | 1 | Some enabled thread can progress |

## Verification
Thread state, address, next address, stall flags and the retry slot are all registered. A redirect, stall, response or selection therefore shows up in status_o, pc_o and npc_o one cycle after the input is held, and the bench samples those outputs one time unit after the next rising edge. The request port and stage_active_o are combinational on the current inputs and state, so the bench checks them in the same cycle, after the inputs have settled and before the edge. Sweeps run over every thread and stage for the sticky flags and over every tag value for response matching. Ordering cases, such as a redirect together with a stall, or commit still squashing together with a decode redirect, are checked one cycle apart to confirm that the priority holds.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   typedef enum logic [3:0] {
      FS_RUN        = 4'd0,
      FS_IDLE       = 4'd1,
      FS_SQUASH     = 4'd2,
      FS_BLOCK      = 4'd3,
      FS_WAIT_RSP   = 4'd4,
      FS_WAIT_RETRY = 4'd5,
      FS_ACC_DONE   = 4'd6,
      FS_TRAP       = 4'd7,
      FS_QUIESCE    = 4'd8
   } fs_state_e;

   localparam int ST_W = 4;

   function automatic logic fs_can_progress(input fs_state_e s);
      return (s == FS_RUN) || (s == FS_SQUASH) || (s == FS_ACC_DONE);
   endfunction
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
   parameter int NS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] set_i,
   input  logic [NS-1:0] clr_i,
   output logic          stalled_nxt_o
);
   logic [NS-1:0] flag_q, flag_n;

   for (genvar s = 0; s < NS; s++) begin : g_stage
      always_comb begin
         flag_n[s] = flag_q[s];
         if (set_i[s])      flag_n[s] = 1'b1;
         else if (clr_i[s]) flag_n[s] = 1'b0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) flag_q[s] <= 1'b0;
         else        flag_q[s] <= flag_n[s];
      end
   end

   assign stalled_nxt_o = |flag_n;
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
   import fsc_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          TAG_W      = 3,
   parameter int          INST_BYTES = 4,
   parameter int          LINE_BYTES = 16,
   parameter logic [15:0] RESET_PC   = 16'h0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stalled_i,
   input  logic              ctx_i,
   input  logic              csq_i,
   input  logic [ADDR_W-1:0] csq_pc_i,
   input  logic              still_i,
   input  logic              dsq_i,
   input  logic [ADDR_W-1:0] dsq_pc_i,
   input  logic              grant_i,
   input  logic              cache_free_i,
   input  logic              req_rdy_i,
   input  logic              slot_done_i,
   input  logic              rsp_hit_i,
   input  logic [TAG_W-1:0]  rsp_tag_i,
   output fs_state_e         state_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic [ADDR_W-1:0] line_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic              issue_o,
   output logic              redirect_o
);
   localparam logic [ADDR_W-1:0] INST_INC  = ADDR_W'(INST_BYTES);
   localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES) - 1'b1);
   localparam logic [ADDR_W-1:0] PC_INIT   = ADDR_W'(RESET_PC);

   fs_state_e         st_q, st_n;
   logic [ADDR_W-1:0] pc_q, pc_n, npc_q, npc_n;
   logic [TAG_W-1:0]  tag_q, tag_n;
   logic              hold;

   assign hold = stalled_i || ctx_i;

   always_comb begin
      st_n       = st_q;
      pc_n       = pc_q;
      npc_n      = npc_q;
      tag_n      = tag_q;
      issue_o    = 1'b0;
      redirect_o = 1'b0;
      if (csq_i) begin
         redirect_o = 1'b1;
         pc_n       = csq_pc_i;
         npc_n      = csq_pc_i + INST_INC;
         st_n       = FS_SQUASH;
      end else if (still_i) begin
         st_n = FS_SQUASH;
      end else if (dsq_i && st_q != FS_SQUASH) begin
         redirect_o = 1'b1;
         pc_n       = dsq_pc_i;
         npc_n      = dsq_pc_i + INST_INC;
         st_n       = FS_SQUASH;
      end else if (hold && st_q != FS_WAIT_RSP) begin
         st_n = FS_BLOCK;
      end else if (st_q == FS_BLOCK || st_q == FS_SQUASH) begin
         st_n = FS_RUN;
      end else begin
         unique case (st_q)
            FS_WAIT_RSP:
               if (rsp_hit_i && rsp_tag_i == tag_q)
                  st_n = hold ? FS_BLOCK : FS_ACC_DONE;
            FS_WAIT_RETRY:
               if (slot_done_i) st_n = FS_WAIT_RSP;
            FS_ACC_DONE:
               if (grant_i) st_n = FS_RUN;
            FS_RUN:
               if (grant_i && cache_free_i) begin
                  issue_o = 1'b1;
                  tag_n   = tag_q + 1'b1;
                  st_n    = req_rdy_i ? FS_WAIT_RSP : FS_WAIT_RETRY;
               end
            default: st_n = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= FS_RUN;
         pc_q  <= PC_INIT;
         npc_q <= PC_INIT + INST_INC;
         tag_q <= '0;
      end else begin
         st_q  <= st_n;
         pc_q  <= pc_n;
         npc_q <= npc_n;
         tag_q <= tag_n;
      end
   end

   assign state_o = st_q;
   assign pc_o    = pc_q;
   assign npc_o   = npc_q;
   assign line_o  = pc_q & LINE_MASK;
   assign tag_o   = tag_q + 1'b1;
endmodule

// File: rtl/fsc_req_slot.sv
module fsc_req_slot #(
   parameter int NT     = 2,
   parameter int ADDR_W = 16,
   parameter int TAG_W  = 3,
   parameter int TID_W  = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NT-1:0]              issue_i,
   input  logic [NT-1:0][ADDR_W-1:0]  line_i,
   input  logic [NT-1:0][TAG_W-1:0]   tag_i,
   input  logic [NT-1:0]              redirect_i,
   input  logic                       req_rdy_i,
   output logic                       req_vld_o,
   output logic [TID_W-1:0]           req_tid_o,
   output logic [ADDR_W-1:0]          req_addr_o,
   output logic [TAG_W-1:0]           req_tag_o,
   output logic                       cache_free_o,
   output logic [NT-1:0]              slot_done_o
);
   logic              slot_vld_q;
   logic [TID_W-1:0]  slot_tid_q, iss_tid;
   logic [ADDR_W-1:0] slot_addr_q;
   logic [TAG_W-1:0]  slot_tag_q;
   logic              iss_any;

   always_comb begin
      iss_any = 1'b0;
      iss_tid = '0;
      for (int t = 0; t < NT; t++) begin
         if (issue_i[t]) begin
            iss_any = 1'b1;
            iss_tid = TID_W'(t);
         end
      end
   end

   assign req_vld_o    = slot_vld_q || iss_any;
   assign req_tid_o    = slot_vld_q ? slot_tid_q  : iss_tid;
   assign req_addr_o   = slot_vld_q ? slot_addr_q : line_i[iss_tid];
   assign req_tag_o    = slot_vld_q ? slot_tag_q  : tag_i[iss_tid];
   assign cache_free_o = !slot_vld_q;

   for (genvar t = 0; t < NT; t++) begin : g_done
      assign slot_done_o[t] = slot_vld_q && req_rdy_i && slot_tid_q == TID_W'(t);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_vld_q  <= 1'b0;
         slot_tid_q  <= '0;
         slot_addr_q <= '0;
         slot_tag_q  <= '0;
      end else if (slot_vld_q) begin
         if (redirect_i[slot_tid_q] || req_rdy_i) slot_vld_q <= 1'b0;
      end else if (iss_any && !req_rdy_i) begin
         slot_vld_q  <= 1'b1;
         slot_tid_q  <= iss_tid;
         slot_addr_q <= line_i[iss_tid];
         slot_tag_q  <= tag_i[iss_tid];
      end
   end
endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
   import fsc_pkg::*;
#(
   parameter int          NT         = 2,
   parameter int          NS         = 4,
   parameter int          ADDR_W     = 16,
   parameter int          TAG_W      = 3,
   parameter int          INST_BYTES = 4,
   parameter int          LINE_BYTES = 16,
   parameter logic [15:0] RESET_PC   = 16'h0100,
   localparam int         TID_W      = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NT-1:0]        thread_act_i,
   input  logic [NT*NS-1:0]     stall_set_i,
   input  logic [NT*NS-1:0]     stall_clr_i,
   input  logic                 ctx_switch_i,
   input  logic                 cmt_sq_vld_i,
   input  logic [TID_W-1:0]     cmt_sq_tid_i,
   input  logic [ADDR_W-1:0]    cmt_sq_pc_i,
   input  logic [NT-1:0]        cmt_still_sq_i,
   input  logic                 dec_sq_vld_i,
   input  logic [TID_W-1:0]     dec_sq_tid_i,
   input  logic [ADDR_W-1:0]    dec_sq_pc_i,
   input  logic                 fetch_go_i,
   input  logic [TID_W-1:0]     fetch_tid_i,
   output logic                 req_vld_o,
   output logic [TID_W-1:0]     req_tid_o,
   output logic [ADDR_W-1:0]    req_addr_o,
   output logic [TAG_W-1:0]     req_tag_o,
   input  logic                 req_rdy_i,
   input  logic                 rsp_vld_i,
   input  logic [TID_W-1:0]     rsp_tid_i,
   input  logic [TAG_W-1:0]     rsp_tag_i,
   output logic [NT*ST_W-1:0]   status_o,
   output logic [NT*ADDR_W-1:0] pc_o,
   output logic [NT*ADDR_W-1:0] npc_o,
   output logic                 stage_active_o
);
   if (NT < 1 || NS < 1) begin : g_bad_count
      $error("thread and stage counts must be at least one");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < INST_BYTES) begin : g_bad_line
      $error("line size must be a power of two no smaller than an instruction");
   end
   if (ADDR_W < $clog2(LINE_BYTES) + 1) begin : g_bad_addr
      $error("address too narrow for the line size");
   end

   fs_state_e                 st_w       [NT];
   logic [NT-1:0][ADDR_W-1:0] line_w;
   logic [NT-1:0][TAG_W-1:0]  tag_w;
   logic [NT-1:0]             issue_w, redirect_w, slot_done_w, stalled_w;
   logic                      cache_free_w;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      fsc_stall_flags #(.NS(NS)) i_flags (
         .clk          (clk),
         .rst_n        (rst_n),
         .set_i        (stall_set_i[t*NS +: NS]),
         .clr_i        (stall_clr_i[t*NS +: NS]),
         .stalled_nxt_o(stalled_w[t])
      );

      fsc_thread_fsm #(
         .ADDR_W(ADDR_W), .TAG_W(TAG_W), .INST_BYTES(INST_BYTES),
         .LINE_BYTES(LINE_BYTES), .RESET_PC(RESET_PC)
      ) i_fsm (
         .clk         (clk),
         .rst_n       (rst_n),
         .stalled_i   (stalled_w[t]),
         .ctx_i       (ctx_switch_i),
         .csq_i       (cmt_sq_vld_i && cmt_sq_tid_i == TID_W'(t)),
         .csq_pc_i    (cmt_sq_pc_i),
         .still_i     (cmt_still_sq_i[t]),
         .dsq_i       (dec_sq_vld_i && dec_sq_tid_i == TID_W'(t)),
         .dsq_pc_i    (dec_sq_pc_i),
         .grant_i     (fetch_go_i && fetch_tid_i == TID_W'(t)),
         .cache_free_i(cache_free_w),
         .req_rdy_i   (req_rdy_i),
         .slot_done_i (slot_done_w[t]),
         .rsp_hit_i   (rsp_vld_i && rsp_tid_i == TID_W'(t)),
         .rsp_tag_i   (rsp_tag_i),
         .state_o     (st_w[t]),
         .pc_o        (pc_o[t*ADDR_W +: ADDR_W]),
         .npc_o       (npc_o[t*ADDR_W +: ADDR_W]),
         .line_o      (line_w[t]),
         .tag_o       (tag_w[t]),
         .issue_o     (issue_w[t]),
         .redirect_o  (redirect_w[t])
      );

      assign status_o[t*ST_W +: ST_W] = st_w[t];
   end

   fsc_req_slot #(
      .NT(NT), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TID_W(TID_W)
   ) i_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_i     (issue_w),
      .line_i      (line_w),
      .tag_i       (tag_w),
      .redirect_i  (redirect_w),
      .req_rdy_i   (req_rdy_i),
      .req_vld_o   (req_vld_o),
      .req_tid_o   (req_tid_o),
      .req_addr_o  (req_addr_o),
      .req_tag_o   (req_tag_o),
      .cache_free_o(cache_free_w),
      .slot_done_o (slot_done_w)
   );

   always_comb begin
      stage_active_o = 1'b0;
      for (int t = 0; t < NT; t++)
         if (thread_act_i[t] && fs_can_progress(st_w[t])) stage_active_o = 1'b1;
   end
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
   import fsc_pkg::*;
#(
   parameter int NT         = 2,
   parameter int NS         = 4,
   parameter int ADDR_W     = 16,
   parameter int TAG_W      = 3,
   parameter int INST_BYTES = 4,
   parameter int TID_W      = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NT*NS-1:0]     stall_set_i,
   input logic [NT*NS-1:0]     stall_clr_i,
   input logic                 cmt_sq_vld_i,
   input logic [TID_W-1:0]     cmt_sq_tid_i,
   input logic [ADDR_W-1:0]    cmt_sq_pc_i,
   input logic [NT-1:0]        cmt_still_sq_i,
   input logic                 req_vld_o,
   input logic [TID_W-1:0]     req_tid_o,
   input logic [ADDR_W-1:0]    req_addr_o,
   input logic [TAG_W-1:0]     req_tag_o,
   input logic                 req_rdy_i,
   input logic [NT*ST_W-1:0]   status_o,
   input logic [NT*ADDR_W-1:0] pc_o,
   input logic [NT*ADDR_W-1:0] npc_o,
   input logic [NT-1:0]        redirect_w
);
   logic [NT-1:0] in_retry;

   for (genvar t = 0; t < NT; t++) begin : g_t
      assign in_retry[t] = status_o[t*ST_W +: ST_W] == ST_W'(FS_WAIT_RETRY);

      AST_CMT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
         (cmt_sq_vld_i && cmt_sq_tid_i == TID_W'(t)) |=>
            (status_o[t*ST_W +: ST_W] == ST_W'(FS_SQUASH) &&
             pc_o[t*ADDR_W +: ADDR_W] == $past(cmt_sq_pc_i) &&
             npc_o[t*ADDR_W +: ADDR_W] == $past(cmt_sq_pc_i) + ADDR_W'(INST_BYTES))); // R4

      AST_STILL_SQUASHING: assert property (@(posedge clk) disable iff (!rst_n)
         cmt_still_sq_i[t] |=> status_o[t*ST_W +: ST_W] == ST_W'(FS_SQUASH)); // R5

      AST_RETRY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         in_retry[t] |-> (req_vld_o && req_tid_o == TID_W'(t))); // R9
   end

   AST_ONE_RETRY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_retry) <= 1); // R9

   AST_HELD_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld_o && !req_rdy_i && !redirect_w[req_tid_o]) |=>
         (req_vld_o && $stable(req_tid_o) && $stable(req_addr_o) && $stable(req_tag_o))); // R9

   AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_set_i & stall_clr_i) == '0); // R2
endmodule

bind fetch_status_ctl fsc_checker #(
   .NT(NT), .NS(NS), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
   .INST_BYTES(INST_BYTES), .TID_W(TID_W)
) i_fsc_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .stall_set_i   (stall_set_i),
   .stall_clr_i   (stall_clr_i),
   .cmt_sq_vld_i  (cmt_sq_vld_i),
   .cmt_sq_tid_i  (cmt_sq_tid_i),
   .cmt_sq_pc_i   (cmt_sq_pc_i),
   .cmt_still_sq_i(cmt_still_sq_i),
   .req_vld_o     (req_vld_o),
   .req_tid_o     (req_tid_o),
   .req_addr_o    (req_addr_o),
   .req_tag_o     (req_tag_o),
   .req_rdy_i     (req_rdy_i),
   .status_o      (status_o),
   .pc_o          (pc_o),
   .npc_o         (npc_o),
   .redirect_w    (redirect_w)
);

// File: tb/test_fetch_status_ctl.sv
module test_fetch_status_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 2, NS = 4, AW = 16, TW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NT-1:0] thread_act;
   logic [7:0]    set_v, clr_v;
   logic          ctx;
   logic          csq_v, dsq_v, go, rdy, rsp_v;
   logic          csq_t, dsq_t, go_t, rsp_t;
   logic [AW-1:0] csq_pc, dsq_pc;
   logic [NT-1:0] still;
   logic [TW-1:0] rsp_tag;
   logic          req_vld, req_tid, stage_act;
   logic [AW-1:0] req_addr;
   logic [TW-1:0] req_tag;
   logic [7:0]    status;
   logic [31:0]   pc, npc;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fetch_status_ctl i_fetch_status_ctl (
      .clk(clk), .rst_n(rst_n), .thread_act_i(thread_act),
      .stall_set_i(set_v), .stall_clr_i(clr_v), .ctx_switch_i(ctx),
      .cmt_sq_vld_i(csq_v), .cmt_sq_tid_i(csq_t), .cmt_sq_pc_i(csq_pc),
      .cmt_still_sq_i(still),
      .dec_sq_vld_i(dsq_v), .dec_sq_tid_i(dsq_t), .dec_sq_pc_i(dsq_pc),
      .fetch_go_i(go), .fetch_tid_i(go_t),
      .req_vld_o(req_vld), .req_tid_o(req_tid), .req_addr_o(req_addr),
      .req_tag_o(req_tag), .req_rdy_i(rdy),
      .rsp_vld_i(rsp_v), .rsp_tid_i(rsp_t), .rsp_tag_i(rsp_tag),
      .status_o(status), .pc_o(pc), .npc_o(npc), .stage_active_o(stage_act)
   );

   function automatic int st(input int t);
      return int'(status[t*4 +: 4]);
   endfunction
   function automatic int pcof(input int t);
      return int'(pc[t*16 +: 16]);
   endfunction
   function automatic int npcof(input int t);
      return int'(npc[t*16 +: 16]);
   endfunction

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   task automatic idle();
      set_v = '0; clr_v = '0; ctx = 0; csq_v = 0; dsq_v = 0; go = 0; rdy = 0;
      rsp_v = 0; csq_t = 0; dsq_t = 0; go_t = 0; rsp_t = 0; still = '0;
      csq_pc = '0; dsq_pc = '0; rsp_tag = '0;
   endtask

   // inputs held until the next rising edge; registered results read 1 unit after it
   task automatic cyc();
      @(posedge clk); #1; idle();
   endtask

   task automatic settle();
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle();
      thread_act = 2'b11;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      settle();
      // R1 reset state
      for (int t = 0; t < NT; t++) begin
         chk("R1 state", st(t), 0);
         chk("R1 pc", pcof(t), 'h100);
         chk("R1 npc", npcof(t), 'h104);
      end
      chk("R1 no request", req_vld, 0);
      chk("R13 active after reset", stage_act, 1);

      // R2 sweep over every thread and stage
      for (int t = 0; t < NT; t++) begin
         for (int s = 0; s < NS; s++) begin
            set_v[t*NS+s] = 1'b1;
            cyc();
            chk("R2 blocked after set", st(t), 3);
            chk("R2 other thread untouched", st(1-t), 0);
            cyc();
            chk("R2 sticky", st(t), 3);
            if (t == 0 && s == 0) begin
               thread_act = 2'b01; settle();
               chk("R13 blocked enabled thread", stage_act, 0);
               thread_act = 2'b10; settle();
               chk("R13 running enabled thread", stage_act, 1);
               thread_act = 2'b11;
            end
            clr_v[t*NS+s] = 1'b1;
            cyc();
            chk("R2 running after clear", st(t), 0);
         end
      end
      // R2 two flags, clear one
      set_v = 8'b0000_0101; cyc();
      clr_v = 8'b0000_0001; cyc();
      chk("R2 one flag left", st(0), 3);
      clr_v = 8'b0000_0100; cyc();
      chk("R2 all cleared", st(0), 0);

      // R3 context switch
      ctx = 1; cyc();
      chk("R3 t0 blocked", st(0), 3);
      chk("R3 t1 blocked", st(1), 3);
      cyc();
      chk("R3 t0 resumes", st(0), 0);
      chk("R3 t1 resumes", st(1), 0);

      // R4 commit redirect with a stall in the same cycle
      csq_v = 1; csq_t = 1; csq_pc = 16'h2346; set_v[4] = 1'b1; cyc();
      chk("R4 squashing", st(1), 2);
      chk("R4 pc", pcof(1), 'h2346);
      chk("R4 npc", npcof(1), 'h234A);
      cyc();
      chk("R4 stall seen after redirect", st(1), 3);
      clr_v[4] = 1'b1; cyc();
      chk("R5 back to running", st(1), 0);

      // R5 still squashing, R6 decode redirect ignored meanwhile
      csq_v = 1; csq_t = 0; csq_pc = 16'h0400; cyc();
      for (int k = 0; k < 2; k++) begin
         still[0] = 1'b1; dsq_v = 1; dsq_t = 0; dsq_pc = 16'h0800; cyc();
         chk("R5 held squashing", st(0), 2);
         chk("R6 decode redirect ignored", pcof(0), 'h0400);
      end
      cyc();
      chk("R5 squash ends", st(0), 0);

      // R6 decode redirect on a running thread, then again while squashing
      dsq_v = 1; dsq_t = 0; dsq_pc = 16'h088A; cyc();
      chk("R6 squashing", st(0), 2);
      chk("R6 pc", pcof(0), 'h088A);
      chk("R6 npc", npcof(0), 'h088E);
      dsq_v = 1; dsq_t = 0; dsq_pc = 16'h0900; cyc();
      chk("R6 second redirect ignored pc", pcof(0), 'h088A);
      chk("R6 second redirect ignored state", st(0), 0);

      // R8 issue accepted
      go = 1; go_t = 0; rdy = 1; settle();
      chk("R8 req valid", req_vld, 1);
      chk("R8 req tid", req_tid, 0);
      chk("R8 req addr", req_addr, 'h0880);
      chk("R8 req tag", req_tag, 1);
      cyc();
      chk("R8 waiting response", st(0), 4);
      chk("R8 request gone", req_vld, 0);

      // R7 stall does not leave WaitResponse
      set_v[1] = 1'b1; cyc();
      chk("R7 stall ignored", st(0), 4);
      ctx = 1; cyc();
      chk("R7 ctx ignored", st(0), 4);

      // R11 tag sweep: only tag 1 on thread 0 matches
      for (int g = 0; g < 8; g++) begin
         if (g != 1) begin
            rsp_v = 1; rsp_t = 0; rsp_tag = TW'(g); cyc();
            chk("R11 wrong tag ignored", st(0), 4);
         end
      end
      rsp_v = 1; rsp_t = 1; rsp_tag = 3'd1; cyc();
      chk("R11 wrong thread ignored", st(0), 4);
      rsp_v = 1; rsp_t = 0; rsp_tag = 3'd1; cyc();
      chk("R11 accepted while stalled", st(0), 3);
      clr_v[1] = 1'b1; cyc();
      chk("R11 resume", st(0), 0);

      // R11 accepted without stall
      go = 1; go_t = 0; rdy = 1; settle();
      chk("R8 second tag", req_tag, 2);
      cyc();
      rsp_v = 1; rsp_t = 0; rsp_tag = 3'd2; cyc();
      chk("R11 access done", st(0), 6);
      thread_act = 2'b01; settle();
      chk("R13 access done counts", stage_act, 1);
      thread_act = 2'b11;

      // R9 refusal by thread 1; R12 thread 0 waits for its own selection
      go = 1; go_t = 1; rdy = 0; settle();
      chk("R8 t1 req tid", req_tid, 1);
      chk("R8 t1 req addr", req_addr, 'h2340);
      chk("R8 t1 req tag", req_tag, 1);
      cyc();
      chk("R9 wait retry", st(1), 5);
      chk("R12 not selected", st(0), 6);
      go = 1; go_t = 0; settle();
      chk("R9 held tid", req_tid, 1);
      chk("R9 held addr", req_addr, 'h2340);
      cyc();
      chk("R12 selected", st(0), 0);
      go = 1; go_t = 0; settle();
      chk("R9 no new request tid", req_tid, 1);
      chk("R9 held tag", req_tag, 1);
      cyc();
      chk("R9 others blocked", st(0), 0);
      rdy = 1; cyc();
      chk("R9 retry accepted", st(1), 4);
      chk("R9 slot empty", req_vld, 0);

      // R10 redirect of slot owner frees the cache
      csq_v = 1; csq_t = 1; csq_pc = 16'h3000; cyc();
      cyc();
      chk("R10 t1 running", st(1), 0);
      go = 1; go_t = 1; rdy = 0; cyc();
      chk("R10 t1 in retry", st(1), 5);
      dsq_v = 1; dsq_t = 1; dsq_pc = 16'h3104; cyc();
      chk("R10 owner squashed", st(1), 2);
      chk("R10 slot emptied", req_vld, 0);
      go = 1; go_t = 0; rdy = 1; settle();
      chk("R10 cache free for t0", req_vld, 1);
      cyc();
      chk("R10 t0 issued", st(0), 4);

      // R13 no enabled thread
      thread_act = 2'b00; settle();
      chk("R13 nothing enabled", stage_act, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule